// File: doc/BRIEF.md
# Programmable Synaptic Delay Buffer

The block holds delayed synaptic input for a group of spiking target neurons. Each target has its own ring of delay cells. Each cell stands for one future time step. A spike event names a target neuron and carries a weight and a latency. The block adds the weight into the cell that will come due after that many time steps. Several connections between the same pair of neurons can use different latencies. Their weights land in different cells of the same ring and do not interfere.

A step strobe advances simulated time. On each strobe, every target's head cell is read out and cleared, and a shared ring pointer moves on by one. The amount read out passes through a second-order response made of two cascaded first-order stages, each with a shift-based leak. The output of the second stage is the synaptic current for that step. Several event ports can write in the same cycle, and their weights are summed with saturation. An event whose latency falls outside the ring is dropped and flagged.

Top module: `syn_delay_buf`

## Requirements
- R1: An accepted event with delay d (1 <= d <= DEPTH) for target n appears in `del_o[n*ACC_W +: ACC_W]` after the d-th step strobe that is sampled strictly after the event's cycle, and is not delivered at any other step.
- R2: Events for the same target and the same due step, arriving in different cycles, accumulate in one cell and are delivered as their sum.
- R3: Events on different ports in the same cycle that hit the same cell are added together.
- R4: Each cell, each response stage and `cur_o` saturate at 2^ACC_W-1 instead of wrapping.
- R5: An event with delay 0 or delay greater than DEPTH is not stored, and `err_o[p]` of its port is 1 in the following cycle. `err_o[p]` is 0 in the cycle after any cycle in which port p carried no such event.
- R6: Targets are independent. An event for one neuron never changes another neuron's delivery or current.
- R7: A cell is cleared when it is delivered. With no new events it delivers 0 when it next comes due, DEPTH steps later.
- R8: On each step, with delivered value v, stage-one state x and current y, the next current is y - (y>>S2) + (x>>S2), using x before its update, and the next x is x - (x>>S1) + v. `cur_o` shows y, so a delivery shows up in `cur_o` one step after it shows up in `del_o`.
- R9: An event that arrives in the same cycle as a step strobe is counted from after that strobe. Delay DEPTH is delivered DEPTH steps later, even though it reuses the cell being cleared in that cycle.
- R10: Without a step strobe, `del_o` and `cur_o` hold their values.
- R11: After reset, every cell, `del_o`, `cur_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Time step strobe |
| ev_valid_i | input | PORTS | Event valid, one bit per port |
| ev_tgt_i | input | PORTS*TGT_W | Target neuron index per port |
| ev_wgt_i | input | PORTS*WGT_W | Unsigned weight per port |
| ev_dly_i | input | PORTS*DLY_W | Delay in steps per port |
| err_o | output | PORTS | Bad-delay flag per port, one cycle after the event |
| del_o | output | N*ACC_W | Amount delivered per neuron at the latest step |
| cur_o | output | N*ACC_W | Second-order synaptic current per neuron |

## Verification
The bench builds the block with four neurons, eight cells, two ports, 8-bit weights, ACC_W = 10, and shifts of 1 and 2. With a 10-bit accumulator, two maximum weights in three consecutive cycles exceed the cell limit, so R4 saturation can be reached in a few cycles. A 4-bit delay field can express 9 to 15 as well as 0, so both kinds of rejected delay can be driven. Eight cells are few enough that a full trip around the ring, the DEPTH-delay corner and its reuse of the cell being cleared all fall within a short directed test.

// File: rtl/syn_dly_pkg.sv
package syn_dly_pkg;
  function automatic bit dly_in_range(int unsigned d, int unsigned depth);
    return (d != 0) && (d <= depth);
  endfunction
endpackage

// File: rtl/syn_dly_sched.sv
module syn_dly_sched #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PORTS = 2,
  parameter int unsigned DLY_W = 4,
  parameter int unsigned PTR_W = 3
) (
  input  logic                   step_i,
  input  logic [PTR_W-1:0]       head_i,
  input  logic [PORTS-1:0]       ev_valid_i,
  input  logic [PORTS*DLY_W-1:0] ev_dly_i,
  output logic [PORTS-1:0]       acc_vld_o,
  output logic [PORTS*PTR_W-1:0] acc_idx_o,
  output logic [PORTS-1:0]       bad_o
);
  import syn_dly_pkg::*;
  localparam int unsigned TW = PTR_W + 2;

  logic [TW-1:0] base;

  // events seen with a step are placed relative to the advanced head
  always_comb begin
    base = step_i ? TW'(head_i) + TW'(1) : TW'(head_i);
    if (base == TW'(DEPTH)) base = '0;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [DLY_W-1:0] d;
    logic [TW-1:0]    t;
    logic             ok;
    assign d  = ev_dly_i[p*DLY_W +: DLY_W];
    assign ok = dly_in_range(32'(d), DEPTH);
    always_comb begin
      t = base + TW'(d) - TW'(1);
      if (t >= TW'(DEPTH)) t = t - TW'(DEPTH);
    end
    assign acc_vld_o[p]               = ev_valid_i[p] && ok;
    assign bad_o[p]                   = ev_valid_i[p] && !ok;
    assign acc_idx_o[p*PTR_W +: PTR_W] = t[PTR_W-1:0];
  end
endmodule

// File: rtl/syn_dly_bank.sv
module syn_dly_bank #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PORTS = 2,
  parameter int unsigned WGT_W = 8,
  parameter int unsigned ACC_W = 12,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned TGT_W = 2,
  parameter int unsigned ID    = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic [PTR_W-1:0]       head_i,
  input  logic [PORTS-1:0]       acc_vld_i,
  input  logic [PORTS*PTR_W-1:0] acc_idx_i,
  input  logic [PORTS*TGT_W-1:0] acc_tgt_i,
  input  logic [PORTS*WGT_W-1:0] acc_wgt_i,
  output logic [ACC_W-1:0]       head_val_o
);
  localparam int unsigned SUM_W = ACC_W + PORTS;

  logic [ACC_W-1:0] cell_val [DEPTH];

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    logic [ACC_W-1:0] q, nxt;
    logic [SUM_W-1:0] sum;
    always_comb begin
      sum = (step_i && head_i == PTR_W'(c)) ? '0 : SUM_W'(q);
      for (int p = 0; p < PORTS; p++) begin
        if (acc_vld_i[p] && acc_tgt_i[p*TGT_W +: TGT_W] == TGT_W'(ID) &&
            acc_idx_i[p*PTR_W +: PTR_W] == PTR_W'(c))
          sum = sum + SUM_W'(acc_wgt_i[p*WGT_W +: WGT_W]);
      end
      nxt = (|sum[SUM_W-1:ACC_W]) ? '1 : sum[ACC_W-1:0];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt;
    end
    assign cell_val[c] = q;
  end

  assign head_val_o = cell_val[head_i];
endmodule

// File: rtl/syn_dly_resp.sv
module syn_dly_resp #(
  parameter int unsigned ACC_W = 12,
  parameter int unsigned S1    = 1,
  parameter int unsigned S2    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [ACC_W-1:0] din_i,
  output logic [ACC_W-1:0] cur_o
);
  logic [ACC_W-1:0] x1_q, x2_q, x1_d, x2_d;
  logic [ACC_W:0]   s1, s2;

  always_comb begin
    s1   = {1'b0, x1_q - (x1_q >> S1)} + {1'b0, din_i};
    s2   = {1'b0, x2_q - (x2_q >> S2)} + {1'b0, x1_q >> S2};
    x1_d = s1[ACC_W] ? '1 : s1[ACC_W-1:0];
    x2_d = s2[ACC_W] ? '1 : s2[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      x2_q <= '0;
    end else if (step_i) begin
      x1_q <= x1_d;
      x2_q <= x2_d;
    end
  end

  assign cur_o = x2_q;
endmodule

// File: rtl/syn_delay_buf.sv
module syn_delay_buf #(
  parameter int unsigned N     = 4,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PORTS = 2,
  parameter int unsigned WGT_W = 8,
  parameter int unsigned ACC_W = 12,
  parameter int unsigned S1    = 1,
  parameter int unsigned S2    = 2,
  localparam int unsigned TGT_W = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned DLY_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic [PORTS-1:0]       ev_valid_i,
  input  logic [PORTS*TGT_W-1:0] ev_tgt_i,
  input  logic [PORTS*WGT_W-1:0] ev_wgt_i,
  input  logic [PORTS*DLY_W-1:0] ev_dly_i,
  output logic [PORTS-1:0]       err_o,
  output logic [N*ACC_W-1:0]     del_o,
  output logic [N*ACC_W-1:0]     cur_o
);
  logic [PTR_W-1:0]       head_q;
  logic [PORTS-1:0]       acc_vld, bad;
  logic [PORTS*PTR_W-1:0] acc_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      err_o  <= '0;
    end else begin
      err_o <= bad;
      if (step_i) head_q <= (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + PTR_W'(1);
    end
  end

  syn_dly_sched #(.DEPTH(DEPTH), .PORTS(PORTS), .DLY_W(DLY_W), .PTR_W(PTR_W)) u_sched (
    .step_i(step_i), .head_i(head_q), .ev_valid_i(ev_valid_i), .ev_dly_i(ev_dly_i),
    .acc_vld_o(acc_vld), .acc_idx_o(acc_idx), .bad_o(bad)
  );

  for (genvar n = 0; n < N; n++) begin : g_nrn
    logic [ACC_W-1:0] head_val, del_q;

    syn_dly_bank #(
      .DEPTH(DEPTH), .PORTS(PORTS), .WGT_W(WGT_W), .ACC_W(ACC_W),
      .PTR_W(PTR_W), .TGT_W(TGT_W), .ID(n)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .head_i(head_q),
      .acc_vld_i(acc_vld), .acc_idx_i(acc_idx), .acc_tgt_i(ev_tgt_i),
      .acc_wgt_i(ev_wgt_i), .head_val_o(head_val)
    );

    syn_dly_resp #(.ACC_W(ACC_W), .S1(S1), .S2(S2)) u_resp (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .din_i(head_val),
      .cur_o(cur_o[n*ACC_W +: ACC_W])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     del_q <= '0;
      else if (step_i) del_q <= head_val;
    end
    assign del_o[n*ACC_W +: ACC_W] = del_q;
  end
endmodule

// File: rtl/syn_delay_buf_chk.sv
module syn_delay_buf_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PORTS = 2,
  parameter int unsigned ACC_W = 12,
  parameter int unsigned DLY_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   step_i,
  input logic [PORTS-1:0]       ev_valid_i,
  input logic [PORTS*DLY_W-1:0] ev_dly_i,
  input logic [PORTS-1:0]       err_o,
  input logic [N*ACC_W-1:0]     del_o,
  input logic [N*ACC_W-1:0]     cur_o
);
  for (genvar p = 0; p < PORTS; p++) begin : g_p
    logic [DLY_W-1:0] d;
    logic             out_of_range;
    assign d            = ev_dly_i[p*DLY_W +: DLY_W];
    assign out_of_range = (d == '0) || (32'(d) > DEPTH);

    AST_ERR_ON_BAD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_i[p] && out_of_range) |=> err_o[p]); // R5
    AST_NO_ERR_ON_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_i[p] && !out_of_range) |=> !err_o[p]); // R5
    AST_NO_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ev_valid_i[p] |=> !err_o[p]); // R5
  end

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(cur_o) && $stable(del_o))); // R10
endmodule

bind syn_delay_buf syn_delay_buf_chk #(
  .N(N), .DEPTH(DEPTH), .PORTS(PORTS), .ACC_W(ACC_W), .DLY_W(DLY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .ev_valid_i(ev_valid_i),
  .ev_dly_i(ev_dly_i), .err_o(err_o), .del_o(del_o), .cur_o(cur_o)
);

// File: tb/syn_delay_buf_bench.sv
module syn_delay_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, DEPTH = 8, PORTS = 2, WGT_W = 8, ACC_W = 10, S1 = 1, S2 = 2;
  localparam int TGT_W = 2, DLY_W = 4;
  localparam int MAXV = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 1'b0;
  logic [PORTS-1:0]       ev_valid_i = '0;
  logic [PORTS*TGT_W-1:0] ev_tgt_i = '0;
  logic [PORTS*WGT_W-1:0] ev_wgt_i = '0;
  logic [PORTS*DLY_W-1:0] ev_dly_i = '0;
  logic [PORTS-1:0]       err_o;
  logic [N*ACC_W-1:0]     del_o, cur_o;

  int tests = 0, fails = 0;
  int sched [N][DEPTH+1];
  int x1 [N], x2 [N], exp_del [N];
  int exp_err [PORTS];
  int ev_t [PORTS], ev_w [PORTS], ev_d [PORTS];
  bit ev_v [PORTS];

  always #(CLK_PERIOD/2) clk = ~clk;

  syn_delay_buf #(.N(N), .DEPTH(DEPTH), .PORTS(PORTS), .WGT_W(WGT_W), .ACC_W(ACC_W),
                  .S1(S1), .S2(S2)) u_syn_delay_buf (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .ev_valid_i(ev_valid_i),
    .ev_tgt_i(ev_tgt_i), .ev_wgt_i(ev_wgt_i), .ev_dly_i(ev_dly_i),
    .err_o(err_o), .del_o(del_o), .cur_o(cur_o)
  );

  function automatic int sat(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_ev(int p, int t, int w, int d);
    ev_v[p] = 1'b1; ev_t[p] = t; ev_w[p] = w; ev_d[p] = d;
  endtask

  // one clock: drive, update model, compare after the edge
  task automatic tick(bit st, string req);
    for (int p = 0; p < PORTS; p++) begin
      ev_valid_i[p] = ev_v[p];
      ev_tgt_i[p*TGT_W +: TGT_W] = TGT_W'(ev_t[p]);
      ev_wgt_i[p*WGT_W +: WGT_W] = WGT_W'(ev_w[p]);
      ev_dly_i[p*DLY_W +: DLY_W] = DLY_W'(ev_d[p]);
    end
    step_i = st;
    if (st) begin
      for (int n = 0; n < N; n++) begin
        int v;
        v = sched[n][1];
        for (int k = 1; k < DEPTH; k++) sched[n][k] = sched[n][k+1];
        sched[n][DEPTH] = 0;
        exp_del[n] = v;
        x2[n] = sat(x2[n] - (x2[n] >> S2) + (x1[n] >> S2));
        x1[n] = sat(x1[n] - (x1[n] >> S1) + v);
      end
    end
    for (int p = 0; p < PORTS; p++) begin
      bit good;
      good = (ev_d[p] != 0) && (ev_d[p] <= DEPTH);
      exp_err[p] = (ev_v[p] && !good) ? 1 : 0;
      if (ev_v[p] && good) sched[ev_t[p]][ev_d[p]] = sat(sched[ev_t[p]][ev_d[p]] + ev_w[p]);
    end
    @(posedge clk);
    @(negedge clk);
    step_i = 1'b0;
    ev_valid_i = '0;
    for (int p = 0; p < PORTS; p++) ev_v[p] = 1'b0;
    for (int p = 0; p < PORTS; p++) chk("R5", $sformatf("err_o[%0d]", p), int'(err_o[p]), exp_err[p]);
    for (int n = 0; n < N; n++) begin
      chk(req, $sformatf("del_o[%0d]", n), int'(del_o[n*ACC_W +: ACC_W]), exp_del[n]);
      chk(req, $sformatf("cur_o[%0d]", n), int'(cur_o[n*ACC_W +: ACC_W]), x2[n]);
    end
  endtask

  task automatic steps(int k, string req);
    for (int i = 0; i < k; i++) tick(1'b1, req);
  endtask

  task automatic t_reset();
    for (int n = 0; n < N; n++) begin
      chk("R11", "del_o after reset", int'(del_o[n*ACC_W +: ACC_W]), 0);
      chk("R11", "cur_o after reset", int'(cur_o[n*ACC_W +: ACC_W]), 0);
    end
    chk("R11", "err_o after reset", int'(err_o), 0);
    steps(DEPTH, "R11");
  endtask

  task automatic t_delay();
    set_ev(0, 0, 20, 3);
    tick(1'b0, "R1");
    steps(DEPTH + 2, "R1");
    steps(DEPTH, "R7");
  endtask

  task automatic t_accumulate();
    set_ev(0, 1, 10, 2);
    tick(1'b0, "R2");
    set_ev(1, 1, 15, 2);
    tick(1'b0, "R2");
    steps(3, "R2");
  endtask

  task automatic t_same_cycle();
    set_ev(0, 2, 100, 4);
    set_ev(1, 2, 55, 4);
    tick(1'b0, "R3");
    steps(5, "R3");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 3; i++) begin
      set_ev(0, 3, 255, 1);
      set_ev(1, 3, 255, 1);
      tick(1'b0, "R4");
    end
    steps(12, "R4");
  endtask

  task automatic t_reject();
    set_ev(0, 0, 77, 0);
    set_ev(1, 1, 88, 9);
    tick(1'b0, "R5");
    set_ev(0, 2, 66, 15);
    tick(1'b1, "R5");
    steps(DEPTH + 1, "R5");
  endtask

  task automatic t_step_same();
    set_ev(0, 0, 40, DEPTH);
    set_ev(1, 1, 30, 1);
    tick(1'b1, "R9");
    steps(DEPTH + 1, "R9");
  endtask

  task automatic t_multi();
    set_ev(0, 0, 12, 2);
    set_ev(1, 0, 34, 5);
    tick(1'b0, "R6");
    set_ev(0, 3, 9, 2);
    set_ev(1, 2, 200, 7);
    tick(1'b0, "R6");
    steps(DEPTH, "R6");
  endtask

  task automatic t_response();
    set_ev(0, 1, 200, 1);
    tick(1'b0, "R8");
    steps(16, "R8");
  endtask

  task automatic t_hold();
    set_ev(0, 2, 120, 1);
    tick(1'b0, "R10");
    steps(2, "R10");
    for (int i = 0; i < 4; i++) tick(1'b0, "R10");
    steps(1, "R10");
  endtask

  initial begin
    for (int n = 0; n < N; n++) begin
      x1[n] = 0; x2[n] = 0; exp_del[n] = 0;
      for (int k = 0; k <= DEPTH; k++) sched[n][k] = 0;
    end
    for (int p = 0; p < PORTS; p++) begin
      ev_v[p] = 1'b0; ev_t[p] = 0; ev_w[p] = 0; ev_d[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_delay();
    t_accumulate();
    t_same_cycle();
    t_saturate();
    t_reject();
    t_step_same();
    t_multi();
    t_response();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule